// File: doc/BRIEF.md
# Dual-Stream Block Merger with Block Skip

This block sits on the receiving side of a two-way sample split. Upstream, one ordered stream of 32-bit complex samples was dealt out in groups of four, alternating between two lanes. The merger reads the two lanes back in the same alternating rhythm and presents the original order on a single ready/valid output.

A 4-bit skip setting tells it how many whole four-sample groups to throw away before any output appears. Discarded groups follow the same alternation as forwarded ones: the first comes from lane 0, the next from lane 1, and so on. For this reason the lane that supplies the first forwarded sample depends on the skip count. An even count resumes on lane 0 and an odd count resumes on lane 1. Dropping a single sample is deliberately impossible, because it would break the interleave. Any sub-group offset is left to the consumer's own compute indexing.

The controller has three states. `ST_LOAD` is entered from reset and whenever `start` is high. It captures `skip_blocks` and clears the lane selector and the in-group counter. From `ST_LOAD` the block goes to `ST_FWD` if the count is zero, otherwise to `ST_DROP`. `ST_DROP` accepts samples from the active lane without forwarding them. It moves to `ST_FWD` when the last group to discard completes. `ST_FWD` forwards samples until the next `start`. A `start` pulse returns any state to `ST_LOAD`.

Top module: `blk_merge_skip`

## Requirements
- R1: With a skip count of 0, output sample order is lane 0 items 0–3, lane 1 items 0–3, lane 0 items 4–7, and so on, each output transfer consuming exactly one input sample.
- R2: At most one lane ready is high in any cycle; the inactive lane's ready stays low so its data waits upstream.
- R3: While discarding, `m_valid` stays low and exactly 4×K input samples are accepted before the first output valid, K being the captured skip count.
- R4: Discarded groups alternate starting with lane 0; the first forwarded sample comes from lane 1 when K is odd and from lane 0 when K is even.
- R5: While `m_valid` is high and `m_ready` low, no input is accepted and `m_valid` and `m_data` hold.
- R6: `skip_done` is low from reset or `start` until the first forwarded transfer, then stays high until the next `start` or reset.
- R7: A one-cycle `start` pulse re-captures `skip_blocks` and restarts the alternation from lane 0.
- R8: The maximum count of 15 discards 60 samples and resumes on lane 1.
- R9: During reset and in the cycle after `start` (state `ST_LOAD`), both lane readies and `m_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse: re-capture skip count and restart from lane 0 |
| skip_blocks | input | 4 | Number of four-sample groups to discard |
| s0_data | input | 32 | Lane 0 sample |
| s0_valid | input | 1 | Lane 0 valid |
| s0_ready | output | 1 | Lane 0 ready |
| s1_data | input | 32 | Lane 1 sample |
| s1_valid | input | 1 | Lane 1 valid |
| s1_ready | output | 1 | Lane 1 ready |
| m_data | output | 32 | Merged output sample |
| m_valid | output | 1 | Merged output valid |
| m_ready | input | 1 | Merged output ready |
| skip_done | output | 1 | High once the first sample has been forwarded |

## Verification
The assertions check the following on every cycle:
- the two lane readies are never high together;
- the output is silent while discarding;
- a stalled output holds its data;
- every output transfer consumes an input;
- the completion flag is sticky;
- the block is quiet in the cycle after a restart.

Three properties need the bench's scenarios because they depend on a whole sequence rather than a single cycle:
- the exact reconstructed order;
- the number of samples swallowed before output starts;
- which lane supplies the first forwarded sample for odd, even and maximum skip counts, both after reset and after `start`.

// File: rtl/blk_merge_pkg.sv
package blk_merge_pkg;
    localparam int NUM_LANES = 2;
    localparam int LANE_W    = $clog2(NUM_LANES);

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_DROP,
        ST_FWD
    } merge_state_e;
endpackage

// File: rtl/blk_merge_phase.sv
// Tracks position inside the current four-sample group and which lane is active.
module blk_merge_phase
    import blk_merge_pkg::*;
#(
    parameter int BLK_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              beat,
    output logic [LANE_W-1:0] sel,
    output logic              blk_end
);
    localparam int CNT_W = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_LEN - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [LANE_W-1:0] sel_q;

    assign blk_end = beat && (cnt_q == LAST);
    assign sel     = sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (beat) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                sel_q <= sel_q + LANE_W'(1);
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/blk_merge_ctrl.sv
// Load / discard / forward sequencing and the completion flag.
module blk_merge_ctrl
    import blk_merge_pkg::*;
#(
    parameter int SKIP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SKIP_W-1:0] skip_in,
    input  logic              blk_end,
    input  logic              fwd_beat,
    output logic              clear,
    output logic              drop_en,
    output logic              fwd_en,
    output logic              done
);
    merge_state_e      state_q, state_d;
    logic [SKIP_W-1:0] left_q;
    logic              done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: state_d = (skip_in == '0) ? ST_FWD : ST_DROP;
            ST_DROP: if (blk_end && (left_q == SKIP_W'(1))) state_d = ST_FWD;
            ST_FWD:  state_d = ST_FWD;
            default: state_d = ST_LOAD;
        endcase
        if (start) state_d = ST_LOAD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (state_q == ST_LOAD) begin
            left_q <= skip_in;
        end else if ((state_q == ST_DROP) && blk_end) begin
            left_q <= left_q - SKIP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (start || (state_q == ST_LOAD)) begin
            done_q <= 1'b0;
        end else if (fwd_beat) begin
            done_q <= 1'b1;
        end
    end

    always_comb begin
        clear   = 1'b0;
        drop_en = 1'b0;
        fwd_en  = 1'b0;
        unique case (state_q)
            ST_LOAD: clear   = 1'b1;
            ST_DROP: drop_en = 1'b1;
            ST_FWD:  fwd_en  = 1'b1;
            default: clear   = 1'b1;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/blk_merge_route.sv
// Lane ready generation and output multiplexing.
module blk_merge_route
    import blk_merge_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_LANES-1:0][DATA_W-1:0] s_data,
    input  logic [NUM_LANES-1:0]             s_valid,
    output logic [NUM_LANES-1:0]             s_ready,
    input  logic [LANE_W-1:0]                sel,
    input  logic                             drop_en,
    input  logic                             fwd_en,
    input  logic                             m_ready,
    output logic [DATA_W-1:0]                m_data,
    output logic                             m_valid,
    output logic                             beat
);
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign s_ready[g] = (sel == LANE_W'(g)) && (drop_en || (fwd_en && m_ready));
    end

    assign m_data  = s_data[sel];
    assign m_valid = fwd_en && s_valid[sel];
    assign beat    = s_valid[sel] && s_ready[sel];
endmodule

// File: rtl/blk_merge_skip.sv
module blk_merge_skip
    import blk_merge_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SKIP_W  = 4,
    parameter int BLK_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SKIP_W-1:0] skip_blocks,
    input  logic [DATA_W-1:0] s0_data,
    input  logic              s0_valid,
    output logic              s0_ready,
    input  logic [DATA_W-1:0] s1_data,
    input  logic              s1_valid,
    output logic              s1_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready,
    output logic              skip_done
);
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_data;
    logic [NUM_LANES-1:0]             lane_valid;
    logic [NUM_LANES-1:0]             lane_ready;
    logic [LANE_W-1:0]                sel;
    logic clear, drop_en, fwd_en, beat, blk_end;

    assign lane_data  = {s1_data, s0_data};
    assign lane_valid = {s1_valid, s0_valid};
    assign s0_ready   = lane_ready[0];
    assign s1_ready   = lane_ready[1];

    blk_merge_ctrl #(.SKIP_W(SKIP_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .skip_in  (skip_blocks),
        .blk_end  (blk_end),
        .fwd_beat (beat && fwd_en),
        .clear    (clear),
        .drop_en  (drop_en),
        .fwd_en   (fwd_en),
        .done     (skip_done)
    );

    blk_merge_phase #(.BLK_LEN(BLK_LEN)) phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .beat    (beat),
        .sel     (sel),
        .blk_end (blk_end)
    );

    blk_merge_route #(.DATA_W(DATA_W)) route_i (
        .s_data  (lane_data),
        .s_valid (lane_valid),
        .s_ready (lane_ready),
        .sel     (sel),
        .drop_en (drop_en),
        .fwd_en  (fwd_en),
        .m_ready (m_ready),
        .m_data  (m_data),
        .m_valid (m_valid),
        .beat    (beat)
    );
endmodule

// File: rtl/blk_merge_chk.sv
module blk_merge_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              s0_valid,
    input logic              s0_ready,
    input logic              s1_valid,
    input logic              s1_ready,
    input logic [DATA_W-1:0] m_data,
    input logic              m_valid,
    input logic              m_ready,
    input logic              skip_done,
    input logic              drop_en
);
    p_one_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(s0_ready && s1_ready));

    p_drop_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        drop_en |-> !m_valid);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready && !start) |=> (m_valid && $stable(m_data)));

    p_out_consumes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready) |-> ((s0_valid && s0_ready) || (s1_valid && s1_ready)));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_done && !start) |=> skip_done);

    p_quiet_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!s0_ready && !s1_ready && !m_valid && !skip_done));
endmodule

bind blk_merge_skip blk_merge_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .s0_valid  (s0_valid),
    .s0_ready  (s0_ready),
    .s1_valid  (s1_valid),
    .s1_ready  (s1_ready),
    .m_data    (m_data),
    .m_valid   (m_valid),
    .m_ready   (m_ready),
    .skip_done (skip_done),
    .drop_en   (drop_en)
);

// File: tb/blk_merge_skip_tb_top.sv
`timescale 1ns/1ps
module blk_merge_skip_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  skip_blocks = '0;
    logic [1:0]  sv = '0;
    logic [31:0] sd [2];
    logic        s0_ready, s1_ready, m_valid, skip_done;
    logic        m_ready = 1'b0;
    logic [31:0] m_data;
    logic [1:0]  rdy;

    int pass_cnt = 0, fail_cnt = 0;
    int lim = 0, gap = 0, bp = 0, cur_k = 0, base = 0;
    int k_cnt [2];
    logic [31:0] exp_q [$];
    int  acc_before = 0, viol2 = 0, viol5 = 0, viol6 = 0, first_bad = 0;
    bit  first_seen = 0, first_pop = 0;

    always #5 clk = ~clk;
    assign rdy = {s1_ready, s0_ready};

    blk_merge_skip dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .skip_blocks(skip_blocks),
        .s0_data(sd[0]), .s0_valid(sv[0]), .s0_ready(s0_ready),
        .s1_data(sd[1]), .s1_valid(sv[1]), .s1_ready(s1_ready),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .skip_done(skip_done)
    );

    function automatic logic [31:0] gdata(input int s, input int k);
        return 32'(base + (k / 4) * 8 + s * 4 + (k % 4));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    endtask

    task automatic drv(input int s);
        bit acc;
        forever begin
            @(negedge clk);
            acc = sv[s] && rdy[s];
            @(posedge clk);
            #1;
            if (acc) k_cnt[s]++;
            if (acc || !sv[s]) begin
                if (k_cnt[s] < lim && $urandom_range(99) >= gap) begin
                    sv[s] = 1'b1;
                    sd[s] = gdata(s, k_cnt[s]);
                end else begin
                    sv[s] = 1'b0;
                end
            end
        end
    endtask

    initial begin
        k_cnt[0] = 0; k_cnt[1] = 0; sd[0] = '0; sd[1] = '0;
        fork drv(0); drv(1); join_none
    end

    initial forever begin
        @(posedge clk); #1;
        m_ready = ($urandom_range(99) >= bp);
    end

    // Monitor: scoreboard pop and per-cycle port rules
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (s0_ready && s1_ready) viol2++;
            if (m_valid && !m_ready && ((sv[0] && s0_ready) || (sv[1] && s1_ready))) viol5++;
            if (!first_seen) begin
                if (m_valid) first_seen = 1;
                else acc_before += int'(sv[0] && s0_ready) + int'(sv[1] && s1_ready);
            end
            if (skip_done && !first_pop) viol6++;
            if (m_valid && m_ready) begin
                if (!first_pop) begin
                    first_pop = 1;
                    if (!rdy[cur_k % 2]) first_bad++;
                end
                if (exp_q.size() == 0) chk(0, "R1 unexpected output", int'(m_data), -1);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(m_data == e, "R1/R4 output order", int'(m_data), int'(e));
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic run_case(input int id, input int k, input int n, input bit use_rst,
                            input int g, input int b, input string tag);
        int waited;
        lim = 0;
        skip_blocks = 4'(k);
        if (use_rst) begin
            @(posedge clk); #1; rst_n = 1'b0;
            repeat (2) @(negedge clk);
            chk(!s0_ready && !s1_ready && !m_valid && !skip_done, "R9 reset quiet",
                int'({s0_ready, s1_ready, m_valid, skip_done}), 0);
            @(posedge clk); #1; rst_n = 1'b1;
        end else begin
            @(posedge clk); #1; start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
            @(negedge clk);
            chk(!s0_ready && !s1_ready && !m_valid && !skip_done, "R9/R6 load quiet after start",
                int'({s0_ready, s1_ready, m_valid, skip_done}), 0);
        end
        @(posedge clk); #1;
        cur_k = k; base = id << 16; gap = g; bp = b;
        k_cnt[0] = 0; k_cnt[1] = 0;
        acc_before = 0; viol2 = 0; viol5 = 0; viol6 = 0; first_bad = 0;
        first_seen = 0; first_pop = 0;
        exp_q.delete();
        for (int i = 4 * k; i < n; i++) exp_q.push_back(32'(base + i));
        lim = n / 2;
        waited = 0;
        while ((exp_q.size() != 0 || k_cnt[0] < lim || k_cnt[1] < lim) && waited < 20000) begin
            @(posedge clk); waited++;
        end
        repeat (3) @(negedge clk);
        chk(waited < 20000, {tag, " case completes"}, waited, 0);
        chk(exp_q.size() == 0, {tag, " all expected samples seen"}, exp_q.size(), 0);
        chk(acc_before == 4 * k, "R3 samples discarded before output", acc_before, 4 * k);
        chk(first_bad == 0, "R4 first forwarded lane", first_bad, 0);
        chk(viol2 == 0, "R2 single lane ready", viol2, 0);
        chk(viol5 == 0, "R5 no intake while stalled", viol5, 0);
        chk(viol6 == 0 && skip_done, "R6 done flag timing", viol6, 0);
    endtask

    initial begin
        run_case(1, 0,  32,  1, 0,  0,  "R1");
        run_case(2, 1,  40,  1, 30, 30, "R4");
        run_case(3, 2,  48,  0, 20, 20, "R7");
        run_case(4, 3,  48,  0, 10, 60, "R5");
        run_case(5, 15, 160, 0, 15, 25, "R8");
        run_case(6, 4,  48,  1, 40, 10, "R3");
        run_case(7, 0,  24,  0, 0,  50, "R7");
        finish_run();
    end
endmodule